// File: doc/BRIEF.md
# Banked Network Parameter Write Decoder

This block sits between a register bus and the per-lane parameter memories of a fixed-point neural network accelerator. Software loads one parameter word at a time by writing a small set of staging registers: a layer number, a memory address, a data word, and a lane number. The lane-number write is the commit. When it names a valid lane, the block issues exactly one write strobe to that lane's memory in the selected layer.

Bias and weight memories each have their own lane-number register, and each drives only its own memory type. Layer and lane numbers count from one. Bias addresses count from zero. Weight addresses count from one, so the block subtracts one before it presents the address to the weight memory. Software is expected to follow a fixed sequence: write zero to the lane number, then write the layer, the data and the address, then write the lane number. Because a zero lane number is not a write, changing the address or data in the middle of this sequence cannot corrupt a stored word.

A strobe fires only when the lane-number register takes a new nonzero value. Writing the same value again does nothing. A layer or lane number outside its range is ignored, and so is a weight address of zero.

Top module: `param_wr_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, both strobe vectors are zero, `bias_addr` is 0 and `mem_data` is 0.
- R2: `reg_sel` selects the register to write: 0 is the layer number, 1 is the address, 2 is the data word, 3 is the bias lane number and 4 is the weight lane number. A write with codes 5 to 7 changes no output.
- R3: A lane-number write of value k (1..NUM_LANES) while the layer register holds L (1..NUM_LAYERS) raises exactly one strobe bit, index (L-1)*NUM_LANES+(k-1). The bit is high in the cycle after the write edge and stays high for that one cycle only.
- R4: Writing zero to a lane-number register produces no strobe.
- R5: Writing the value a lane-number register already holds produces no strobe. Changing it from one nonzero value to a different nonzero value produces a strobe.
- R6: `bias_addr` equals the address register. `wgt_addr` equals the address register minus one, modulo 2^ADDR_W.
- R7: If the address register holds 0 when the weight lane number is committed, no weight strobe is produced.
- R8: A lane number greater than NUM_LANES, a layer number of 0, or a layer number greater than NUM_LAYERS produces no strobe.
- R9: A bias lane-number write can raise only `bias_we` bits. A weight lane-number write can raise only `wgt_we` bits.
- R10: `mem_data` equals the data register whenever a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write request for this cycle |
| reg_sel | input | 3 | Register select code (see R2) |
| reg_wdata | input | DATA_W | Register write data |
| bias_we | output | NUM_LAYERS*NUM_LANES | Bias memory write strobes, one per layer and lane |
| bias_addr | output | ADDR_W | Zero-based bias memory address |
| wgt_we | output | NUM_LAYERS*NUM_LANES | Weight memory write strobes, one per layer and lane |
| wgt_addr | output | ADDR_W | Weight memory address after the one-based correction |
| mem_data | output | DATA_W | Parameter word presented to all memories |

## Verification
If a staged register is corrupted, the wrong strobe index or a wrong address or data value appears in the very cycle the commit strobe is high. No later write is needed to expose it. If the held lane number is lost, the fault shows up on the next commit: a repeated write then fires when it should not, or a changed write stays silent when it should fire. If the strobe register never clears, a second strobe cycle shows up one cycle after the commit. The bench sweeps every layer and lane number, including the out-of-range ones, on both paths. It checks the strobe vector in the commit cycle and again in the cycle after.

// File: rtl/pwd_pkg.sv
`timescale 1ns/1ps
package pwd_pkg;
   typedef enum logic [2:0] {
      SEL_LAYER   = 3'd0,
      SEL_ADDR    = 3'd1,
      SEL_DATA    = 3'd2,
      SEL_BIAS_EN = 3'd3,
      SEL_WGT_EN  = 3'd4
   } pwd_sel_e;
endpackage

// File: rtl/pwd_stage_regs.sv
`timescale 1ns/1ps
module pwd_stage_regs #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 10,
   parameter int NUM_LAYERS = 4,
   parameter int LAYER_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [LAYER_W-1:0] layer_q,
   output logic              layer_ok,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);
   import pwd_pkg::*;

   logic layer_in_range;
   assign layer_in_range = (wdata != '0) && (wdata <= DATA_W'(NUM_LAYERS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         layer_q  <= '0;
         layer_ok <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
      end else if (wr) begin
         case (sel)
            SEL_LAYER: begin
               layer_q  <= wdata[LAYER_W-1:0];
               layer_ok <= layer_in_range;
            end
            SEL_ADDR: addr_q <= wdata[ADDR_W-1:0];
            SEL_DATA: data_q <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pwd_lane_strobe.sv
`timescale 1ns/1ps
module pwd_lane_strobe #(
   parameter int DATA_W     = 32,
   parameter int NUM_LANES  = 4,
   parameter int NUM_LAYERS = 4,
   parameter int LAYER_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LAYER_W-1:0] layer_q,
   input  logic              layer_ok,
   input  logic              target_ok,
   output logic [NUM_LAYERS*NUM_LANES-1:0] strobe
);
   localparam int NSTR = NUM_LAYERS * NUM_LANES;

   logic [DATA_W-1:0] en_q;
   logic [NSTR-1:0]   hit;
   logic [NSTR-1:0]   strobe_d;
   logic              commit;

   // A commit is a write that moves the held lane number to a new value.
   assign commit = en_wr && (wdata != en_q) && layer_ok && target_ok;

   for (genvar gl = 0; gl < NUM_LAYERS; gl++) begin : g_layer
      for (genvar gk = 0; gk < NUM_LANES; gk++) begin : g_lane
         assign hit[gl*NUM_LANES + gk] =
            (layer_q == LAYER_W'(gl + 1)) && (wdata == DATA_W'(gk + 1));
      end
   end

   assign strobe_d = commit ? hit : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         strobe <= '0;
      end else begin
         if (en_wr) en_q <= wdata;
         strobe <= strobe_d;
      end
   end
endmodule

// File: rtl/param_wr_decoder.sv
`timescale 1ns/1ps
module param_wr_decoder #(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 10,
   parameter int NUM_LANES     = 4,
   parameter int NUM_LAYERS    = 4,
   parameter bit WGT_ONE_BASED = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            reg_wr,
   input  logic [2:0]                      reg_sel,
   input  logic [DATA_W-1:0]               reg_wdata,
   output logic [NUM_LAYERS*NUM_LANES-1:0] bias_we,
   output logic [ADDR_W-1:0]               bias_addr,
   output logic [NUM_LAYERS*NUM_LANES-1:0] wgt_we,
   output logic [ADDR_W-1:0]               wgt_addr,
   output logic [DATA_W-1:0]               mem_data
);
   import pwd_pkg::*;

   localparam int LAYER_W = $clog2(NUM_LAYERS + 1);

   if (NUM_LANES < 1 || NUM_LAYERS < 1) begin : g_bad_count
      $error("param_wr_decoder: lane and layer counts must be at least 1");
   end
   if (DATA_W < ADDR_W || DATA_W < LAYER_W) begin : g_bad_width
      $error("param_wr_decoder: DATA_W must cover address and layer fields");
   end

   logic [LAYER_W-1:0] layer_q;
   logic               layer_ok;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;
   logic               wgt_addr_ok;

   pwd_stage_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .NUM_LAYERS(NUM_LAYERS), .LAYER_W(LAYER_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .layer_q(layer_q), .layer_ok(layer_ok), .addr_q(addr_q), .data_q(data_q)
   );

   if (WGT_ONE_BASED) begin : g_wgt_one
      assign wgt_addr    = addr_q - ADDR_W'(1);
      assign wgt_addr_ok = (addr_q != '0);
   end else begin : g_wgt_zero
      assign wgt_addr    = addr_q;
      assign wgt_addr_ok = 1'b1;
   end

   assign bias_addr = addr_q;
   assign mem_data  = data_q;

   pwd_lane_strobe #(
      .DATA_W(DATA_W), .NUM_LANES(NUM_LANES),
      .NUM_LAYERS(NUM_LAYERS), .LAYER_W(LAYER_W)
   ) u_bias_str (
      .clk(clk), .rst_n(rst_n),
      .en_wr(reg_wr && (reg_sel == SEL_BIAS_EN)),
      .wdata(reg_wdata), .layer_q(layer_q), .layer_ok(layer_ok),
      .target_ok(1'b1), .strobe(bias_we)
   );

   pwd_lane_strobe #(
      .DATA_W(DATA_W), .NUM_LANES(NUM_LANES),
      .NUM_LAYERS(NUM_LAYERS), .LAYER_W(LAYER_W)
   ) u_wgt_str (
      .clk(clk), .rst_n(rst_n),
      .en_wr(reg_wr && (reg_sel == SEL_WGT_EN)),
      .wdata(reg_wdata), .layer_q(layer_q), .layer_ok(layer_ok),
      .target_ok(wgt_addr_ok), .strobe(wgt_we)
   );
endmodule

// File: rtl/param_wr_decoder_chk.sv
`timescale 1ns/1ps
module param_wr_decoder_chk #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 10,
   parameter int NUM_LANES  = 4,
   parameter int NUM_LAYERS = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            reg_wr,
   input logic [2:0]                      reg_sel,
   input logic [DATA_W-1:0]               reg_wdata,
   input logic [NUM_LAYERS*NUM_LANES-1:0] bias_we,
   input logic [ADDR_W-1:0]               bias_addr,
   input logic [NUM_LAYERS*NUM_LANES-1:0] wgt_we,
   input logic [ADDR_W-1:0]               wgt_addr,
   input logic [DATA_W-1:0]               mem_data
);
   assert_bias_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bias_we));
   assert_wgt_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wgt_we));
   assert_bias_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bias_we != '0) |-> $past(reg_wr && reg_sel == 3'd3 && reg_wdata != '0));
   assert_wgt_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wgt_we != '0) |-> $past(reg_wr && reg_sel == 3'd4 && reg_wdata != '0));
   assert_zero_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 3'd3 && reg_wdata == '0) |=> (bias_we == '0));
   assert_zero_wgt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 3'd4 && reg_wdata == '0) |=> (wgt_we == '0));
   assert_wgt_addr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wgt_we != '0) |-> (wgt_addr != '1));
   assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((bias_we | wgt_we) != '0) |-> ($stable(bias_addr) && $stable(mem_data)));
endmodule

bind param_wr_decoder param_wr_decoder_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .NUM_LANES(NUM_LANES), .NUM_LAYERS(NUM_LAYERS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .reg_wdata(reg_wdata), .bias_we(bias_we), .bias_addr(bias_addr),
   .wgt_we(wgt_we), .wgt_addr(wgt_addr), .mem_data(mem_data)
);

// File: tb/param_wr_decoder_tb_top.sv
`timescale 1ns/1ps
module param_wr_decoder_tb_top;
   localparam int DW = 32, AW = 10, NL = 4, NY = 4, NS = NL * NY;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_sel = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [NS-1:0] bias_we, wgt_we;
   logic [AW-1:0] bias_addr, wgt_addr;
   logic [DW-1:0] mem_data;

   int vec = 0;
   int bad = 0;

   always #2 clk = ~clk;

   param_wr_decoder #(.DATA_W(DW), .ADDR_W(AW), .NUM_LANES(NL), .NUM_LAYERS(NY)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .bias_we(bias_we), .bias_addr(bias_addr),
      .wgt_we(wgt_we), .wgt_addr(wgt_addr), .mem_data(mem_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [DW-1:0] v);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 bias_we", 64'(bias_we), 0);
      chk("R1 wgt_we", 64'(wgt_we), 0);
      chk("R1 bias_addr", 64'(bias_addr), 0);
      chk("R1 mem_data", 64'(mem_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 64'(bias_we | wgt_we), 0);

      // Sweep of both paths over all in-range and out-of-range layer/lane values
      for (int p = 0; p < 2; p++) begin
         for (int ly = 0; ly <= NY + 1; ly++) begin
            for (int ln = 0; ln <= NL + 1; ln++) begin
               logic [2:0]    esel;
               logic [DW-1:0] d;
               logic [AW-1:0] a;
               logic          ok;
               logic [NS-1:0] ev;
               esel = (p == 1) ? 3'd4 : 3'd3;
               d = 32'hA000 + DW'(p * 256 + ly * 16 + ln);
               a = AW'((ly + ln) % 5);
               wr(esel, 0);
               wr(3'd0, DW'(ly));
               wr(3'd2, d);
               wr(3'd1, DW'(a));
               wr(esel, DW'(ln));
               ok = (ly >= 1 && ly <= NY && ln >= 1 && ln <= NL && (p == 0 || a != 0));
               ev = ok ? (NS'(1) << ((ly - 1) * NL + ln - 1)) : '0;
               if (p == 0) begin
                  chk("R3 R8 bias strobe", 64'(bias_we), 64'(ev));
                  chk("R9 no weight strobe", 64'(wgt_we), 0);
               end else begin
                  chk("R3 R7 R8 weight strobe", 64'(wgt_we), 64'(ev));
                  chk("R9 no bias strobe", 64'(bias_we), 0);
               end
               chk("R6 bias_addr", 64'(bias_addr), 64'(a));
               chk("R6 wgt_addr", 64'(wgt_addr), 64'(AW'(a - AW'(1))));
               chk("R10 mem_data", 64'(mem_data), 64'(d));
               @(negedge clk);
               chk("R3 single cycle", 64'(bias_we | wgt_we), 0);
            end
         end
      end

      // Held value, changed value and zero
      wr(3'd3, 0);
      chk("R4 zero write", 64'(bias_we), 0);
      wr(3'd0, 2);
      wr(3'd1, 5);
      wr(3'd3, 3);
      chk("R3 layer2 lane3", 64'(bias_we), 64'(NS'(1) << 6));
      @(negedge clk);
      wr(3'd3, 3);
      chk("R5 repeated value", 64'(bias_we), 0);
      wr(3'd3, 1);
      chk("R5 changed value", 64'(bias_we), 64'(NS'(1) << 4));

      // Unused select codes leave every output unchanged
      for (int s = 5; s < 8; s++) begin
         wr(3'(s), 32'h3);
         chk("R2 unused sel strobes", 64'(bias_we | wgt_we), 0);
         chk("R2 unused sel addr", 64'(bias_addr), 5);
         chk("R2 unused sel data", 64'(mem_data), 64'(32'hA000 + 256 + 5 * 16 + 5));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule